// File: doc/BRIEF.md
# Host-to-DSP Memory Access Window

This block is a host-side bridge. Through a handful of 16-bit ports, a host can read and write the two local memories of a DSP. One memory is a data store of 16-bit words. The other is an instruction store of 32-bit words. The host places a 32-bit window address into two address ports, one for each 16-bit half. It then moves words through a shared data port. Bit 22 of the window address chooses the instruction store. When that bit is set, the word index is taken from address bits just above bit 1, so the host forms the window address as the index shifted left by two with bit 22 set.

An instruction word travels as two halves. The host first touches the low-half port and then the shared data port, and the order is the same for reads and for writes. A written low half waits in a staging register. The full word is stored only when the high half arrives. A read-and-clear port returns a data-store word and leaves zero in its place. When the auto-increment bit of the control port is set, the window address advances after each completed access: by one for a data-store access, and by four after the high half of an instruction word. Host bus timing is reduced to single-cycle read and write strobes, and read data is registered.

Top module: `host_mem_window`

## Requirements
- R1: After reset the window address, the control register and the read data are zero. The window address is loaded as two halves. Select 0 writes and reads bits 15:0, and select 1 writes and reads bits 31:16.
- R2: With address bit 22 clear, select 2 (the data port) writes or reads the 16-bit data-store word indexed by the low log2(DS_WORDS) address bits.
- R3: With bit 22 set, a write to select 3 (the low-half port) stages 16 bits. A later write to select 2 stores {written value, staged value} as the instruction word at index address[2 +: log2(IS_WORDS)]. A low-half write alone leaves memory unchanged.
- R4: With bit 22 set, a read of select 3 returns bits 15:0 of the addressed instruction word, and a read of select 2 returns bits 31:16.
- R5: With bit 22 clear, a read of select 4 (read-and-clear) returns the addressed data-store word and leaves zero there. With bit 22 set, it returns zero and changes no memory or address.
- R6: Bit 0 of select 5 is auto-increment. When it is set, each data-store access through select 2 or 4 adds 1 to the window address, and each select-2 instruction access adds 4. Low-half accesses never move the address. When the bit is clear, the address never moves on its own.
- R7: Address bits above each store's index field are ignored, so indices wrap within each store. Advancing past the last data word reaches word 0.
- R8: Read data is registered. It is valid in the cycle after the read strobe and holds until the next read. If write and read strobes are both asserted, only the write is performed.
- R9: With bit 22 clear, the low-half port is ignored: a write does not change the staged value, and a read returns zero.
- R10: A new window address takes effect on the very next data access, without prefetch.
- R11: Selects 6 and 7 read as zero, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hb_sel | input | 3 | Port select for the current strobe |
| hb_wr | input | 1 | Single-cycle write strobe |
| hb_rd | input | 1 | Single-cycle read strobe |
| hb_wdata | input | 16 | Write data |
| hb_rdata | output | 16 | Registered read data |

## Verification
A wrong address state appears at the ports one cycle after the faulty access. It shows when the address halves are read back, and it shows as data taken from the neighbouring word on the next data access, so every scenario reads the address back after its transfers. A staging register that is lost or overwritten only becomes visible once a later high-half write commits a word and that word is read back. The bench therefore commits a word after ignored low-half writes and checks both halves. A read-and-clear that fails to clear is exposed by the second read of the same location.

// File: rtl/hmw_pkg.sv
package hmw_pkg;
  typedef enum logic [2:0] {
    PORT_ADDR_LO = 3'd0,
    PORT_ADDR_HI = 3'd1,
    PORT_DATA    = 3'd2,
    PORT_ILO     = 3'd3,
    PORT_RCLR    = 3'd4,
    PORT_CTRL    = 3'd5
  } port_e;

  localparam int ISEL_BIT = 22;

  function automatic logic in_istore(input logic [31:0] a);
    return a[ISEL_BIT];
  endfunction

  function automatic logic [31:0] step_addr(input logic [31:0] a);
    return a + (in_istore(a) ? 32'd4 : 32'd1);
  endfunction
endpackage

// File: rtl/mw_window_reg.sv
module mw_window_reg
  import hmw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        lo_we,
  input  logic        hi_we,
  input  logic        ctrl_we,
  input  logic        adv,
  input  logic [15:0] wdata,
  output logic [31:0] addr,
  output logic        autoinc
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr    <= '0;
      autoinc <= 1'b0;
    end else begin
      if (lo_we)      addr[15:0]  <= wdata;
      else if (hi_we) addr[31:16] <= wdata;
      else if (adv)   addr        <= step_addr(addr);
      if (ctrl_we)    autoinc     <= wdata[0];
    end
  end
endmodule

// File: rtl/mw_ds_mem.sv
module mw_ds_mem #(
  parameter int WORDS = 256,
  localparam int AW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic          clr,
  input  logic [AW-1:0] idx,
  input  logic [15:0]   wdata,
  output logic [15:0]   rdata
);
  logic [15:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we)       mem[idx] <= wdata;
    else if (clr) mem[idx] <= '0;
  end

  assign rdata = mem[idx];
endmodule

// File: rtl/mw_is_mem.sv
module mw_is_mem #(
  parameter int WORDS = 64,
  localparam int AW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stage_we,
  input  logic          commit,
  input  logic [AW-1:0] idx,
  input  logic [15:0]   wdata,
  output logic [31:0]   rdata
);
  logic [31:0] mem [WORDS];
  logic [15:0] stage_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        stage_q <= '0;
    else if (stage_we) stage_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (commit) mem[idx] <= {wdata, stage_q};
  end

  assign rdata = mem[idx];
endmodule

// File: rtl/host_mem_window.sv
module host_mem_window
  import hmw_pkg::*;
#(
  parameter int DS_WORDS = 256,
  parameter int IS_WORDS = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  hb_sel,
  input  logic        hb_wr,
  input  logic        hb_rd,
  input  logic [15:0] hb_wdata,
  output logic [15:0] hb_rdata
);
  localparam int DS_AW = (DS_WORDS > 1) ? $clog2(DS_WORDS) : 1;
  localparam int IS_AW = (IS_WORDS > 1) ? $clog2(IS_WORDS) : 1;

  logic [31:0]      win_addr;
  logic             autoinc;
  logic             in_is;
  logic [DS_AW-1:0] ds_idx;
  logic [IS_AW-1:0] is_idx;
  logic [15:0]      ds_rdata;
  logic [31:0]      is_rdata;
  logic [15:0]      rd_mux;
  logic [15:0]      rdata_q;

  // named internal events
  logic wr_ev, rd_ev;
  logic ds_wr_ev, ds_rd_ev, rac_ev;
  logic is_lo_wr_ev, is_lo_rd_ev, is_commit_ev, is_hi_rd_ev;
  logic data_done, adv_ev;

  assign in_is  = in_istore(win_addr);
  assign ds_idx = win_addr[DS_AW-1:0];
  assign is_idx = win_addr[2 +: IS_AW];

  // a write strobe takes precedence over a simultaneous read
  assign wr_ev = hb_wr;
  assign rd_ev = hb_rd & ~hb_wr;

  assign ds_wr_ev     = wr_ev & (hb_sel == PORT_DATA) & ~in_is;
  assign ds_rd_ev     = rd_ev & (hb_sel == PORT_DATA) & ~in_is;
  assign rac_ev       = rd_ev & (hb_sel == PORT_RCLR) & ~in_is;
  assign is_commit_ev = wr_ev & (hb_sel == PORT_DATA) & in_is;
  assign is_hi_rd_ev  = rd_ev & (hb_sel == PORT_DATA) & in_is;
  assign is_lo_wr_ev  = wr_ev & (hb_sel == PORT_ILO) & in_is;
  assign is_lo_rd_ev  = rd_ev & (hb_sel == PORT_ILO) & in_is;

  assign data_done = ds_wr_ev | ds_rd_ev | rac_ev | is_commit_ev | is_hi_rd_ev;
  assign adv_ev    = data_done & autoinc;

  mw_window_reg u_win (
    .clk     (clk),
    .rst_n   (rst_n),
    .lo_we   (wr_ev & (hb_sel == PORT_ADDR_LO)),
    .hi_we   (wr_ev & (hb_sel == PORT_ADDR_HI)),
    .ctrl_we (wr_ev & (hb_sel == PORT_CTRL)),
    .adv     (adv_ev),
    .wdata   (hb_wdata),
    .addr    (win_addr),
    .autoinc (autoinc)
  );

  mw_ds_mem #(.WORDS(DS_WORDS)) u_ds (
    .clk   (clk),
    .we    (ds_wr_ev),
    .clr   (rac_ev),
    .idx   (ds_idx),
    .wdata (hb_wdata),
    .rdata (ds_rdata)
  );

  mw_is_mem #(.WORDS(IS_WORDS)) u_is (
    .clk      (clk),
    .rst_n    (rst_n),
    .stage_we (is_lo_wr_ev),
    .commit   (is_commit_ev),
    .idx      (is_idx),
    .wdata    (hb_wdata),
    .rdata    (is_rdata)
  );

  always_comb begin
    rd_mux = '0;
    case (hb_sel)
      PORT_ADDR_LO: rd_mux = win_addr[15:0];
      PORT_ADDR_HI: rd_mux = win_addr[31:16];
      PORT_DATA:    rd_mux = in_is ? is_rdata[31:16] : ds_rdata;
      PORT_ILO:     rd_mux = in_is ? is_rdata[15:0] : 16'h0;
      PORT_RCLR:    rd_mux = in_is ? 16'h0 : ds_rdata;
      PORT_CTRL:    rd_mux = {15'h0, autoinc};
      default:      rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_ev) rdata_q <= rd_mux;
  end

  assign hb_rdata = rdata_q;
endmodule

// File: rtl/hmw_checker.sv
module hmw_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  hb_sel,
  input logic        hb_wr,
  input logic [15:0] hb_wdata,
  input logic [15:0] hb_rdata,
  input logic [31:0] win_addr,
  input logic        autoinc,
  input logic [15:0] ds_rdata,
  input logic        ds_wr_ev,
  input logic        ds_rd_ev,
  input logic        rac_ev,
  input logic        is_lo_wr_ev,
  input logic        is_lo_rd_ev,
  input logic        is_commit_ev,
  input logic        is_hi_rd_ev,
  input logic        adv_ev
);
  assert_adv_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    adv_ev |-> autoinc);

  assert_adv_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    adv_ev |=> win_addr == $past(win_addr) + ($past(win_addr[22]) ? 32'd4 : 32'd1));

  assert_lo_half_still_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_lo_wr_ev || is_lo_rd_ev) |=> win_addr == $past(win_addr));

  assert_rac_returns_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rac_ev |=> hb_rdata == $past(ds_rdata));

  assert_rac_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rac_ev && !autoinc) |=> ds_rdata == 16'h0);

  assert_single_op_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ds_wr_ev, ds_rd_ev, rac_ev, is_lo_wr_ev, is_lo_rd_ev, is_commit_ev, is_hi_rd_ev}));

  assert_addr_lo_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (hb_wr && hb_sel == 3'd0) |=> win_addr[15:0] == $past(hb_wdata));
endmodule

bind host_mem_window hmw_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .hb_sel       (hb_sel),
  .hb_wr        (hb_wr),
  .hb_wdata     (hb_wdata),
  .hb_rdata     (hb_rdata),
  .win_addr     (win_addr),
  .autoinc      (autoinc),
  .ds_rdata     (ds_rdata),
  .ds_wr_ev     (ds_wr_ev),
  .ds_rd_ev     (ds_rd_ev),
  .rac_ev       (rac_ev),
  .is_lo_wr_ev  (is_lo_wr_ev),
  .is_lo_rd_ev  (is_lo_rd_ev),
  .is_commit_ev (is_commit_ev),
  .is_hi_rd_ev  (is_hi_rd_ev),
  .adv_ev       (adv_ev)
);

// File: tb/host_mem_window_test.sv
module host_mem_window_test;
  localparam int DS_WORDS = 256;
  localparam int IS_WORDS = 64;
  localparam logic [2:0] S_LO = 3'd0, S_HI = 3'd1, S_DATA = 3'd2,
                         S_ILO = 3'd3, S_RCLR = 3'd4, S_CTRL = 3'd5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  hb_sel = '0;
  logic        hb_wr = 1'b0;
  logic        hb_rd = 1'b0;
  logic [15:0] hb_wdata = '0;
  logic [15:0] hb_rdata;

  int checks = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  host_mem_window #(.DS_WORDS(DS_WORDS), .IS_WORDS(IS_WORDS)) uut (
    .clk(clk), .rst_n(rst_n), .hb_sel(hb_sel), .hb_wr(hb_wr),
    .hb_rd(hb_rd), .hb_wdata(hb_wdata), .hb_rdata(hb_rdata));

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] s, input logic [15:0] d);
    @(negedge clk);
    hb_sel = s; hb_wdata = d; hb_wr = 1'b1;
    @(negedge clk);
    hb_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] s, output logic [15:0] d);
    @(negedge clk);
    hb_sel = s; hb_rd = 1'b1;
    @(negedge clk);
    hb_rd = 1'b0;
    d = hb_rdata;
  endtask

  task automatic set_addr(input logic [31:0] a);
    bus_wr(S_LO, a[15:0]);
    bus_wr(S_HI, a[31:16]);
  endtask

  task automatic get_addr(output logic [31:0] a);
    logic [15:0] lo, hi;
    bus_rd(S_LO, lo);
    bus_rd(S_HI, hi);
    a = {hi, lo};
  endtask

  function automatic logic [31:0] is_addr(input int idx);
    return (32'(idx) << 2) | (32'd1 << 22);
  endfunction

  task automatic t_reset();
    logic [15:0] v;
    check("R1 reset rdata", 32'(hb_rdata), 32'h0);
    bus_rd(S_LO, v);   check("R1 reset addr lo", 32'(v), 32'h0);
    bus_rd(S_HI, v);   check("R1 reset addr hi", 32'(v), 32'h0);
    bus_rd(S_CTRL, v); check("R1 reset ctrl", 32'(v), 32'h0);
  endtask

  task automatic t_addr_load();
    logic [31:0] a;
    set_addr(32'h1234_5678);
    get_addr(a);
    check("R1 address halves", a, 32'h1234_5678);
  endtask

  task automatic t_ds_autoinc();
    logic [15:0] v;
    logic [31:0] a;
    bus_wr(S_CTRL, 16'h1);
    set_addr(32'h0000_0010);
    for (int i = 0; i < 4; i++) bus_wr(S_DATA, 16'hA000 + 16'(i));
    get_addr(a);
    check("R6 ds advance by one", a, 32'h0000_0014);
    set_addr(32'h0000_0010);
    for (int i = 0; i < 4; i++) begin
      bus_rd(S_DATA, v);
      check("R2 ds readback", 32'(v), 32'hA000 + 32'(i));
    end
  endtask

  task automatic t_is_words();
    logic [15:0] v;
    logic [31:0] a;
    set_addr(is_addr(4));
    for (int i = 0; i < 3; i++) begin
      bus_wr(S_ILO, 16'h1100 + 16'(i));
      get_addr(a);
      check("R6 low half holds address", a, is_addr(4 + i));
      bus_wr(S_DATA, 16'hC000 + 16'(i));
    end
    get_addr(a);
    check("R6 is advance by four", a, is_addr(7));
    set_addr(is_addr(4));
    for (int i = 0; i < 3; i++) begin
      bus_rd(S_ILO, v);
      check("R4 is low half", 32'(v), 32'h1100 + 32'(i));
      bus_rd(S_DATA, v);
      check("R4 is high half", 32'(v), 32'hC000 + 32'(i));
    end
    // a staged low half without its high half does not reach memory (R3)
    set_addr(is_addr(5));
    bus_wr(S_ILO, 16'hDEAD);
    bus_rd(S_ILO, v);
    check("R3 no commit on low only", 32'(v), 32'h1101);
  endtask

  task automatic t_rac();
    logic [15:0] v;
    logic [31:0] a;
    bus_wr(S_CTRL, 16'h0);
    set_addr(32'h0000_0030);
    bus_wr(S_DATA, 16'h5A5A);
    bus_rd(S_RCLR, v);
    check("R5 read-and-clear value", 32'(v), 32'h5A5A);
    bus_rd(S_DATA, v);
    check("R5 location cleared", 32'(v), 32'h0);
    get_addr(a);
    check("R6 no advance when off", a, 32'h0000_0030);
    set_addr(is_addr(6));
    bus_rd(S_RCLR, v);
    check("R5 rclr in istore zero", 32'(v), 32'h0);
    bus_rd(S_DATA, v);
    check("R5 istore untouched", 32'(v), 32'hC002);
    get_addr(a);
    check("R5 rclr istore no move", a, is_addr(6));
  endtask

  task automatic t_wrap();
    logic [15:0] v;
    logic [31:0] a;
    bus_wr(S_CTRL, 16'h1);
    set_addr(32'(DS_WORDS - 1));
    bus_wr(S_DATA, 16'h7001);
    bus_wr(S_DATA, 16'h7002);
    get_addr(a);
    check("R7 address after wrap", a, 32'(DS_WORDS + 1));
    set_addr(32'h0001_0000);
    bus_rd(S_DATA, v);
    check("R7 upper bits ignored word0", 32'(v), 32'h7002);
    set_addr(32'(DS_WORDS - 1) | 32'h0008_0000);
    bus_rd(S_DATA, v);
    check("R7 upper bits ignored last", 32'(v), 32'h7001);
  endtask

  task automatic t_hold_and_collide();
    logic [15:0] v;
    bus_wr(S_CTRL, 16'h0);
    set_addr(32'h0000_0020);
    bus_wr(S_DATA, 16'h1111);
    bus_rd(S_DATA, v);
    repeat (3) @(negedge clk);
    check("R8 rdata holds", 32'(hb_rdata), 32'h1111);
    @(negedge clk);
    hb_sel = S_DATA; hb_wdata = 16'h2222; hb_wr = 1'b1; hb_rd = 1'b1;
    @(negedge clk);
    hb_wr = 1'b0; hb_rd = 1'b0;
    check("R8 collide no read", 32'(hb_rdata), 32'h1111);
    bus_rd(S_DATA, v);
    check("R8 collide write done", 32'(v), 32'h2222);
  endtask

  task automatic t_lo_in_ds_space();
    logic [15:0] v;
    set_addr(32'h0000_0040);
    bus_wr(S_ILO, 16'hAAAA);
    bus_rd(S_ILO, v);
    check("R9 low port reads zero", 32'(v), 32'h0);
    // staged value is still 0xDEAD from t_is_words
    set_addr(is_addr(9));
    bus_wr(S_DATA, 16'h4321);
    bus_rd(S_ILO, v);
    check("R9 stage not overwritten", 32'(v), 32'hDEAD);
    bus_rd(S_DATA, v);
    check("R3 committed high", 32'(v), 32'h4321);
  endtask

  task automatic t_addr_immediate();
    logic [15:0] v;
    set_addr(32'h0000_0050);
    bus_wr(S_DATA, 16'h0B0B);
    bus_wr(S_LO, 16'h0051);
    bus_wr(S_DATA, 16'h0C0C);
    bus_wr(S_LO, 16'h0050);
    bus_rd(S_DATA, v);
    check("R10 new address used", 32'(v), 32'h0B0B);
    bus_wr(S_LO, 16'h0051);
    bus_rd(S_DATA, v);
    check("R10 second address used", 32'(v), 32'h0C0C);
  endtask

  task automatic t_unused();
    logic [15:0] v;
    logic [31:0] a;
    bus_wr(3'd6, 16'hFFFF);
    bus_wr(3'd7, 16'hFFFF);
    bus_rd(3'd7, v);
    check("R11 unused reads zero", 32'(v), 32'h0);
    bus_rd(3'd6, v);
    check("R11 unused reads zero", 32'(v), 32'h0);
    get_addr(a);
    check("R11 address untouched", a, 32'h0000_0051);
    bus_rd(S_CTRL, v);
    check("R11 ctrl untouched", 32'(v), 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_addr_load();
    t_ds_autoinc();
    t_is_words();
    t_rac();
    t_wrap();
    t_hold_and_collide();
    t_lo_in_ds_space();
    t_addr_immediate();
    t_unused();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule